// File: doc/BRIEF.md
# Page Program Data Buffer

This block handles the data phase of a page program command for a serial flash whose pages are 256 bytes. The command decoder pulses `cmd_start` once it has seen the program opcode (02h) and the three address bytes. It presents the full start address along with that pulse. After that, the decoder forwards every serial data bit latched on a rising SCK edge, one system clock cycle per bit. The block packs the bits into bytes, most significant bit first. It places each byte in a local page buffer at the position given by the running low address byte. That position wraps inside the page. A per-entry valid mask records which positions were filled.

When the chip enable rises (`cs_rise`), the command is accepted only if four conditions hold: a whole number of bytes was received, at least one data byte arrived, and both the write-enable permit and the protection permit are high. If any condition fails, the buffered data is dropped. An accepted command starts the internal program cycle. The block walks the 256 buffer positions, one per cycle. For each filled position it reads the old byte through a combinational memory read port. It then writes back the old byte ANDed with the new byte, so bits can only be cleared. After the walk, a parameterised program time elapses. Then `done` pulses for one cycle, which the status logic uses to clear its write-enable latch. `busy` is the write-in-progress flag.

Top module: `page_prog_buffer`

## Requirements
- R1: After reset `busy`, `done` and `mem_wr_en` are 0 and the block waits for `cmd_start`.
- R2: Data bits are packed into bytes MSB first. The first byte goes to page position `start_addr[7:0]`, and each later byte goes to the next position. All writes target the page `start_addr[ADDR_W-1:8]`.
- R3: When the position passes 255 it wraps to 0 within the same page. The upper address bits never change during a command.
- R4: When more than 256 bytes are sent, a later byte overwrites an earlier one at the same position, so only the last 256 bytes are programmed.
- R5: Page positions that received no byte, and every other page, keep their old contents.
- R6: Each programmed location becomes old value AND new value; a 0 bit is never turned into 1.
- R7: If the number of data bits at `cs_rise` is not a multiple of 8, the command is discarded: no memory write, `busy` stays 0 and `done` stays 0.
- R8: A command that ends with zero data bytes is discarded in the same way.
- R9: If `wel_ok` or `prot_ok` is 0 at `cs_rise`, the command is discarded in the same way.
- R10: An accepted command raises `busy` in the cycle after `cs_rise`. `busy` stays high for exactly 256 + `PROG_CYCLES` cycles. `done` then pulses for one cycle with `busy` low.
- R11: While `busy` is high, `cmd_start`, data bits and `cs_rise` are ignored.
- R12: Data bits and `cs_rise` outside a command have no effect, and memory is written only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Program opcode and address received (one-cycle pulse) |
| start_addr | input | ADDR_W | Start address of the command |
| bit_valid | input | 1 | One serial data bit latched this cycle |
| bit_in | input | 1 | Value of that data bit |
| cs_rise | input | 1 | Chip enable went inactive (end of command) |
| wel_ok | input | 1 | Write-enable latch is set |
| prot_ok | input | 1 | Target page is not write-protected |
| mem_rd_addr | output | ADDR_W | Array read address (combinational read) |
| mem_rd_data | input | 8 | Old byte at `mem_rd_addr` |
| mem_wr_en | output | 1 | Array write strobe |
| mem_wr_addr | output | ADDR_W | Array write address |
| mem_wr_data | output | 8 | Byte to store (old AND new) |
| busy | output | 1 | Program in progress |
| done | output | 1 | One-cycle end-of-program pulse |

## Verification
The bench sends short bursts in mid-page, where only the touched bytes may change. It sends a burst that crosses the page end, which separates wrapping from spilling into the next page. It sends an over-long burst of 300 bytes, which shows whether older bytes are overwritten. It also reprograms a page that was already programmed; ANDed data differs from plainly copied data only there. The rejected endings are tested one at a time: a trailing partial byte, no data, a missing write enable and a protected page. In each case the memory image and the `busy`/`done` flags must stay untouched. Directed cases then aim a second command at the block while it is busy, and send stray bits when no command is open.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_COMMIT,
        ST_HOLD,
        ST_DONE
    } ppb_state_e;
endpackage

// File: rtl/ppb_byte_asm.sv
module ppb_byte_asm #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_val,
    output logic              aligned
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
    } asm_s;

    asm_s asm_d, asm_q;

    always_comb begin
        asm_d    = asm_q;
        byte_stb = 1'b0;
        byte_val = {asm_q.sh[BYTE_W-2:0], bit_in};
        if (clear) begin
            asm_d = '0;
        end else if (bit_valid) begin
            asm_d.sh = byte_val;
            if (asm_q.cnt == LAST) begin
                asm_d.cnt = '0;
                byte_stb  = 1'b1;
            end else begin
                asm_d.cnt = asm_q.cnt + 1'b1;
            end
        end
    end

    assign aligned = (asm_q.cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) asm_q <= '0;
        else        asm_q <= asm_d;
    end
endmodule

// File: rtl/ppb_page_store.sv
module ppb_page_store #(
    parameter int DEPTH = 256,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_mask,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [W-1:0]             wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [W-1:0]             rd_data,
    output logic                     rd_valid
);
    logic [W-1:0]     ent_q [DEPTH];
    logic [DEPTH-1:0] vld_d, vld_q;

    always_comb begin
        vld_d = vld_q;
        if (clr_mask)   vld_d = '0;
        else if (wr_en) vld_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == g)) ent_q[g] <= wr_data;
        end
    end

    assign rd_data  = ent_q[rd_idx];
    assign rd_valid = vld_q[rd_idx];
endmodule

// File: rtl/ppb_ctrl.sv
module ppb_ctrl
    import ppb_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int PAGE_W      = 8,
    parameter int PROG_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              cs_rise,
    input  logic              aligned,
    input  logic              byte_stb,
    input  logic              wel_ok,
    input  logic              prot_ok,
    input  logic              st_rd_valid,
    output logic              collecting,
    output logic              asm_clear,
    output logic              clr_mask,
    output logic              buf_wr_en,
    output logic [PAGE_W-1:0] buf_wr_idx,
    output logic [PAGE_W-1:0] buf_rd_idx,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr_en,
    output logic              busy,
    output logic              done
);
    localparam int HI_W  = ADDR_W - PAGE_W;
    localparam int TMR_W = $clog2(PROG_CYCLES + 1);
    localparam logic [PAGE_W-1:0] IDX_LAST = '1;
    localparam logic [TMR_W-1:0]  TMR_LOAD = TMR_W'(PROG_CYCLES - 1);

    typedef struct packed {
        ppb_state_e        st;
        logic [HI_W-1:0]   page;
        logic [PAGE_W-1:0] ptr;
        logic [PAGE_W-1:0] idx;
        logic [TMR_W-1:0]  tmr;
        logic              any;
    } ctl_s;

    ctl_s c_d, c_q;

    always_comb begin
        c_d        = c_q;
        collecting = 1'b0;
        asm_clear  = 1'b0;
        clr_mask   = 1'b0;
        buf_wr_en  = 1'b0;
        mem_wr_en  = 1'b0;
        busy       = 1'b0;
        done       = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (cmd_start) begin
                    c_d.st    = ST_COLLECT;
                    c_d.page  = start_addr[ADDR_W-1:PAGE_W];
                    c_d.ptr   = start_addr[PAGE_W-1:0];
                    c_d.any   = 1'b0;
                    asm_clear = 1'b1;
                    clr_mask  = 1'b1;
                end
            end
            ST_COLLECT: begin
                collecting = 1'b1;
                if (cs_rise) begin
                    if (aligned && c_q.any && wel_ok && prot_ok) begin
                        c_d.st  = ST_COMMIT;
                        c_d.idx = '0;
                    end else begin
                        c_d.st = ST_IDLE;
                    end
                end else if (byte_stb) begin
                    buf_wr_en = 1'b1;
                    c_d.ptr   = c_q.ptr + 1'b1;
                    c_d.any   = 1'b1;
                end
            end
            ST_COMMIT: begin
                busy      = 1'b1;
                mem_wr_en = st_rd_valid;
                if (c_q.idx == IDX_LAST) begin
                    c_d.st  = ST_HOLD;
                    c_d.tmr = TMR_LOAD;
                end else begin
                    c_d.idx = c_q.idx + 1'b1;
                end
            end
            ST_HOLD: begin
                busy = 1'b1;
                if (c_q.tmr == '0) c_d.st  = ST_DONE;
                else               c_d.tmr = c_q.tmr - 1'b1;
            end
            ST_DONE: begin
                done   = 1'b1;
                c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    assign buf_wr_idx = c_q.ptr;
    assign buf_rd_idx = c_q.idx;
    assign mem_addr   = {c_q.page, c_q.idx};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, default: '0};
        else        c_q <= c_d;
    end
endmodule

// File: rtl/page_prog_buffer.sv
module page_prog_buffer #(
    parameter int ADDR_W      = 18,
    parameter int PROG_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              cs_rise,
    input  logic              wel_ok,
    input  logic              prot_ok,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [7:0]        mem_wr_data,
    output logic              busy,
    output logic              done
);
    localparam int BYTE_W     = 8;
    localparam int PAGE_BYTES = 256;
    localparam int PAGE_W     = $clog2(PAGE_BYTES);

    logic              collecting, asm_clear, clr_mask, buf_wr_en;
    logic              byte_stb, aligned, st_rd_valid;
    logic [BYTE_W-1:0] byte_val, st_rd_data;
    logic [PAGE_W-1:0] buf_wr_idx, buf_rd_idx;
    logic [ADDR_W-1:0] mem_addr;

    ppb_byte_asm #(.BYTE_W(BYTE_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (asm_clear),
        .bit_valid (bit_valid & collecting),
        .bit_in    (bit_in),
        .byte_stb  (byte_stb),
        .byte_val  (byte_val),
        .aligned   (aligned)
    );

    ppb_page_store #(.DEPTH(PAGE_BYTES), .W(BYTE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_mask (clr_mask),
        .wr_en    (buf_wr_en),
        .wr_idx   (buf_wr_idx),
        .wr_data  (byte_val),
        .rd_idx   (buf_rd_idx),
        .rd_data  (st_rd_data),
        .rd_valid (st_rd_valid)
    );

    ppb_ctrl #(
        .ADDR_W      (ADDR_W),
        .PAGE_W      (PAGE_W),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_start   (cmd_start),
        .start_addr  (start_addr),
        .cs_rise     (cs_rise),
        .aligned     (aligned),
        .byte_stb    (byte_stb),
        .wel_ok      (wel_ok),
        .prot_ok     (prot_ok),
        .st_rd_valid (st_rd_valid),
        .collecting  (collecting),
        .asm_clear   (asm_clear),
        .clr_mask    (clr_mask),
        .buf_wr_en   (buf_wr_en),
        .buf_wr_idx  (buf_wr_idx),
        .buf_rd_idx  (buf_rd_idx),
        .mem_addr    (mem_addr),
        .mem_wr_en   (mem_wr_en),
        .busy        (busy),
        .done        (done)
    );

    assign mem_rd_addr = mem_addr;
    assign mem_wr_addr = mem_addr;
    assign mem_wr_data = mem_rd_data & st_rd_data;
endmodule

// File: rtl/ppb_checker.sv
module ppb_checker #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_rise,
    input logic              busy,
    input logic              done,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [7:0]        mem_rd_data,
    input logic [7:0]        mem_wr_data
);
    p_write_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> busy);

    p_clear_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ((mem_wr_data & ~mem_rd_data) == 8'h00));

    p_busy_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise));

    p_done_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done}));

    p_same_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && mem_wr_en && $past(mem_wr_en)) |->
        (mem_wr_addr[ADDR_W-1:8] == $past(mem_wr_addr[ADDR_W-1:8])));
endmodule

bind page_prog_buffer ppb_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_rise     (cs_rise),
    .busy        (busy),
    .done        (done),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr),
    .mem_rd_data (mem_rd_data),
    .mem_wr_data (mem_wr_data)
);

// File: tb/page_prog_buffer_bench.sv
module page_prog_buffer_bench;
    localparam int AW   = 12;
    localparam int PROG = 40;
    localparam int MEMN = 1 << AW;
    localparam int BUSY_LEN = 256 + PROG;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          bit_valid = 1'b0;
    logic          bit_in = 1'b0;
    logic          cs_rise = 1'b0;
    logic          wel_ok = 1'b0;
    logic          prot_ok = 1'b0;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;
    logic [7:0]    mem_rd_data, mem_wr_data;
    logic          mem_wr_en, busy, done;

    always #4 clk = ~clk;

    page_prog_buffer #(.ADDR_W(AW), .PROG_CYCLES(PROG)) u_page_prog_buffer (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_addr(start_addr),
        .bit_valid(bit_valid), .bit_in(bit_in), .cs_rise(cs_rise),
        .wel_ok(wel_ok), .prot_ok(prot_ok), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .busy(busy), .done(done)
    );

    logic [7:0] mem  [MEMN];
    logic [7:0] expm [MEMN];
    assign mem_rd_data = mem[mem_rd_addr];
    always @(posedge clk) if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] dat(input logic [7:0] s, input int i);
        return 8'(s * 8'd29 + 8'(i * 7)) ^ 8'h96;
    endfunction

    function automatic int mem_diff();
        int n = 0;
        for (int a = 0; a < MEMN; a++) if (mem[a] !== expm[a]) n++;
        return n;
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in    = b;
    endtask

    task automatic open_cmd(input logic [AW-1:0] a);
        @(negedge clk);
        bit_valid  = 1'b0;
        cmd_start  = 1'b1;
        start_addr = a;
        @(negedge clk);
        cmd_start  = 1'b0;
    endtask

    task automatic send_data(input int n, input logic [7:0] s, input int extra);
        for (int i = 0; i < n; i++) begin
            logic [7:0] v = dat(s, i);
            for (int b = 7; b >= 0; b--) send_bit(v[b]);
        end
        for (int e = 0; e < extra; e++) send_bit(1'b1);
    endtask

    task automatic close_cmd(input logic w, input logic p);
        @(negedge clk);
        bit_valid = 1'b0;
        wel_ok    = w;
        prot_ok   = p;
        cs_rise   = 1'b1;
        @(negedge clk);
        cs_rise   = 1'b0;
    endtask

    task automatic model_commit(input logic [AW-1:0] a, input int n, input logic [7:0] s);
        logic [7:0] lastv [256];
        bit         sent  [256];
        for (int k = 0; k < 256; k++) sent[k] = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic [7:0] pos = a[7:0] + 8'(i);
            lastv[pos] = dat(s, i);
            sent[pos]  = 1'b1;
        end
        for (int k = 0; k < 256; k++)
            if (sent[k]) expm[{a[AW-1:8], 8'(k)}] &= lastv[k];
    endtask

    task automatic wait_commit(input string req);
        int len = 0;
        check(busy === 1'b1, req, "busy after cs_rise", int'(busy), 1);
        while (busy === 1'b1 && len < 5000) begin
            len++;
            @(negedge clk);
        end
        check(len == BUSY_LEN, "R10", "busy length", len, BUSY_LEN);
        check(done === 1'b1, "R10", "done pulse", int'(done), 1);
        @(negedge clk);
        check(done === 1'b0, "R10", "done single cycle", int'(done), 0);
    endtask

    task automatic wait_quiet(input string req);
        int seen = 0;
        for (int k = 0; k < BUSY_LEN + 20; k++) begin
            if (busy !== 1'b0 || done !== 1'b0) seen++;
            @(negedge clk);
        end
        check(seen == 0, req, "busy/done stayed low", seen, 0);
    endtask

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [9:0]    nbytes;
        logic [7:0]    seed;
        logic          wel;
        logic          prot;
        logic [2:0]    extra;
        logic          commit;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{12'h100, 10'd4,   8'h01, 1'b1, 1'b1, 3'd0, 1'b1}, // R2 mid-page
        '{12'h2FC, 10'd10,  8'h02, 1'b1, 1'b1, 3'd0, 1'b1}, // R3 wrap
        '{12'h310, 10'd300, 8'h03, 1'b1, 1'b1, 3'd0, 1'b1}, // R4 overlong
        '{12'h100, 10'd4,   8'h44, 1'b1, 1'b1, 3'd0, 1'b1}, // R6 reprogram
        '{12'h450, 10'd5,   8'h05, 1'b1, 1'b1, 3'd3, 1'b0}, // R7 partial byte
        '{12'h500, 10'd0,   8'h06, 1'b1, 1'b1, 3'd0, 1'b0}, // R8 no data
        '{12'h600, 10'd6,   8'h07, 1'b0, 1'b1, 3'd0, 1'b0}, // R9 no write enable
        '{12'h700, 10'd6,   8'h08, 1'b1, 1'b0, 3'd0, 1'b0}, // R9 protected
        '{12'h5F0, 10'd1,   8'h09, 1'b1, 1'b1, 3'd0, 1'b1}  // R5 single byte
    };

    localparam string VREQ [9] = '{"R2", "R3", "R4", "R6", "R7", "R8", "R9", "R9", "R5"};

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < MEMN; a++) begin
            mem[a]  = 8'(a * 53 + 17);
            expm[a] = 8'(a * 53 + 17);
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy === 1'b0 && done === 1'b0 && mem_wr_en === 1'b0, "R1", "reset outputs",
              int'({busy, done, mem_wr_en}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy === 1'b0 && mem_wr_en === 1'b0, "R1", "idle after reset",
              int'({busy, mem_wr_en}), 0);

        for (int v = 0; v < 9; v++) begin
            vec_t t = VECS[v];
            open_cmd(t.addr);
            send_data(int'(t.nbytes), t.seed, int'(t.extra));
            close_cmd(t.wel, t.prot);
            if (t.commit) begin
                model_commit(t.addr, int'(t.nbytes), t.seed);
                wait_commit(VREQ[v]);
            end else begin
                wait_quiet(VREQ[v]);
            end
            check(mem_diff() == 0, VREQ[v], "memory image", mem_diff(), 0);
        end

        // R11 command while busy is ignored
        open_cmd(12'h800);
        send_data(3, 8'h0A, 0);
        close_cmd(1'b1, 1'b1);
        model_commit(12'h800, 3, 8'h0A);
        open_cmd(12'h900);
        send_data(2, 8'h0B, 0);
        close_cmd(1'b1, 1'b1);
        while (busy === 1'b1) @(negedge clk);
        @(negedge clk);
        wait_quiet("R11");
        check(mem_diff() == 0, "R11", "only first command applied", mem_diff(), 0);

        // R12 stray bits and cs_rise with no open command
        send_data(2, 8'h0C, 0);
        close_cmd(1'b1, 1'b1);
        wait_quiet("R12");
        check(mem_diff() == 0, "R12", "memory after stray bits", mem_diff(), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule